// File: doc/BRIEF.md
# USB CRC16 Residual Checker

This block checks the 16-bit CRC that protects the data field of a received USB packet. Each data byte is offered with a valid strobe. A start pulse opens a packet and an end pulse closes it. The data bytes and the two CRC bytes that were sent with them are fed through a right-shifting register. This register uses the reflected generator constant 0xA001 and is preset to 0xFFFF. The packet identifier is not fed in. When the end pulse arrives, the block does not rebuild the transmitted CRC field. It compares the register against the fixed value that every intact packet leaves behind, which is 0xB001.

A parameter chooses how one byte is folded in. One variant chains eight single-bit steps in logic. The other indexes a 256-entry table that is computed from the generator at elaboration and looks up the low register byte XOR the data byte. It then XORs the entry with the old high byte. Both variants give the same result. The running register value is visible on an output, so a receive path can watch it.

The control is a two-state machine:
- `ST_IDLE` waits for a start pulse. While idle, bytes and end pulses are ignored.
- `ST_ACCUM` takes in bytes.
- The transition *open* (IDLE→ACCUM) happens on a start pulse.
- The transition *restart* (ACCUM→ACCUM) happens on a start pulse during a packet and presets the register again.
- The transition *close* (ACCUM→IDLE, or IDLE→IDLE when start and end arrive together) happens on an end pulse and schedules the verdict.

Top module: `crc16_residual_check`

## Requirements
- R1: After reset `crc_value` is 0xFFFF and `crc_ok` and `crc_fail` are both low.
- R2: A start pulse presets the register to 0xFFFF. If `data_valid` is high in the same cycle, that byte is folded into 0xFFFF, so the first byte is not lost.
- R3: Each accepted byte replaces the register `c` with `T[c[7:0] ^ d] ^ (c >> 8)`. Here `T[i]` is eight right shifts of `i`, and a shift XORs in 0xA001 whenever the bit shifted out is 1. For example, T[0x01] = 0xC0C1, T[0x54] = 0xFF01, and byte 0xFE after a preset gives 0xC03E. The new value appears on `crc_value` one cycle after the byte. Cycles with `data_valid` low leave the register unchanged.
- R4: While no packet is open, bytes and end pulses without a start pulse have no effect. `crc_value` holds and no verdict is produced.
- R5: An end pulse that closes a packet drives exactly one of `crc_ok` and `crc_fail` high for exactly one cycle, in the cycle after the pulse. A byte offered in the same cycle as the end pulse is included. `crc_ok` means the register equals 0xB001.
- R6: A packet closed after fewer than two accepted bytes reports `crc_fail`, whatever the register holds.
- R7: A start pulse in the cycle right after an end pulse opens a new packet that is checked normally.
- R8: The unrolled bitwise variant and the table variant produce identical `crc_value`, `crc_ok` and `crc_fail` on every cycle.
- R9: A start pulse during an open packet throws away the partial result and begins a fresh packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_start | input | 1 | Opens a packet; presets the register |
| pkt_end | input | 1 | Closes the packet; triggers the residual compare |
| data_valid | input | 1 | Qualifies `data_in` |
| data_in | input | 8 | Received data byte, processed LSB first |
| crc_value | output | 16 | Current register contents |
| crc_ok | output | 1 | One-cycle pulse: residual matched |
| crc_fail | output | 1 | One-cycle pulse: residual mismatched or packet too short |

## Verification
The bench checks the first byte offered in the same cycle as the start pulse. A design that presets after folding in that byte would end every packet with a wrong residual. The bench also checks a final byte offered together with the end pulse; a design that compares the old register would flag good packets as failures. One-byte and empty packets must fail even if the register happens to match, and a design without the byte count would pass them. Bytes and end pulses sent while idle must not move the register or produce a verdict. A start pulse right after an end pulse, and a restart in the middle of a packet, show whether the state machine drops or merges packets.

// File: rtl/crc16_chk_pkg.sv
package crc16_chk_pkg;
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ACCUM = 1'b1
    } chk_state_e;
endpackage

// File: rtl/crc16_bit_step.sv
module crc16_bit_step #(
    parameter int              CRC_W = 16,
    parameter logic [CRC_W-1:0] POLY = 16'hA001
) (
    input  logic [CRC_W-1:0] crc_in,
    input  logic             bit_in,
    output logic [CRC_W-1:0] crc_out
);
    logic feedback;
    assign feedback = crc_in[0] ^ bit_in;
    assign crc_out  = (crc_in >> 1) ^ (feedback ? POLY : '0);
endmodule

// File: rtl/crc16_table_rom.sv
module crc16_table_rom #(
    parameter int               CRC_W  = 16,
    parameter int               DATA_W = 8,
    parameter logic [CRC_W-1:0] POLY   = 16'hA001
) (
    input  logic [DATA_W-1:0] idx,
    output logic [CRC_W-1:0]  entry
);
    localparam int TBL_N = 1 << DATA_W;

    function automatic logic [CRC_W-1:0] entry_of(input int i);
        logic [CRC_W-1:0] c;
        c = CRC_W'(i);
        for (int s = 0; s < DATA_W; s++) begin
            c = c[0] ? ((c >> 1) ^ POLY) : (c >> 1);
        end
        return c;
    endfunction

    logic [CRC_W-1:0] tbl [TBL_N];

    for (genvar g = 0; g < TBL_N; g++) begin : g_tbl
        assign tbl[g] = entry_of(g);
    end

    assign entry = tbl[idx];
endmodule

// File: rtl/crc16_byte_update.sv
module crc16_byte_update #(
    parameter int               CRC_W   = 16,
    parameter int               DATA_W  = 8,
    parameter logic [CRC_W-1:0] POLY    = 16'hA001,
    parameter bit               USE_LUT = 1'b0
) (
    input  logic [CRC_W-1:0]  crc_in,
    input  logic [DATA_W-1:0] data_in,
    output logic [CRC_W-1:0]  crc_out
);
    if (USE_LUT) begin : g_lut
        logic [DATA_W-1:0] index;
        logic [CRC_W-1:0]  looked;
        assign index = crc_in[DATA_W-1:0] ^ data_in;
        crc16_table_rom #(.CRC_W(CRC_W), .DATA_W(DATA_W), .POLY(POLY)) u_rom (
            .idx   (index),
            .entry (looked)
        );
        assign crc_out = looked ^ (crc_in >> DATA_W);
    end else begin : g_bits
        logic [CRC_W-1:0] chain [DATA_W+1];
        assign chain[0] = crc_in;
        for (genvar k = 0; k < DATA_W; k++) begin : g_step
            crc16_bit_step #(.CRC_W(CRC_W), .POLY(POLY)) u_step (
                .crc_in  (chain[k]),
                .bit_in  (data_in[k]),
                .crc_out (chain[k+1])
            );
        end
        assign crc_out = chain[DATA_W];
    end
endmodule

// File: rtl/crc16_residual_check.sv
module crc16_residual_check
    import crc16_chk_pkg::*;
#(
    parameter int               CRC_W     = 16,
    parameter int               DATA_W    = 8,
    parameter logic [CRC_W-1:0] POLY      = 16'hA001,
    parameter logic [CRC_W-1:0] INIT      = 16'hFFFF,
    parameter logic [CRC_W-1:0] RESIDUE   = 16'hB001,
    parameter int               MIN_BYTES = 2,
    parameter bit               USE_LUT   = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pkt_start,
    input  logic              pkt_end,
    input  logic              data_valid,
    input  logic [DATA_W-1:0] data_in,
    output logic [CRC_W-1:0]  crc_value,
    output logic              crc_ok,
    output logic              crc_fail
);
    localparam int CNT_W = $clog2(MIN_BYTES + 1);
    localparam logic [CNT_W-1:0] CNT_MIN = CNT_W'(MIN_BYTES);

    chk_state_e       state_q, state_d;
    logic [CRC_W-1:0] crc_q, crc_d, crc_base, crc_upd;
    logic [CNT_W-1:0] cnt_q, cnt_d, cnt_base;
    logic             ok_q, fail_q, ok_d, fail_d;
    logic             accept, closing;

    assign crc_base = pkt_start ? INIT : crc_q;
    assign cnt_base = pkt_start ? '0 : cnt_q;
    assign accept   = data_valid && (pkt_start || state_q == ST_ACCUM);
    assign closing  = pkt_end && (pkt_start || state_q == ST_ACCUM);

    crc16_byte_update #(
        .CRC_W(CRC_W), .DATA_W(DATA_W), .POLY(POLY), .USE_LUT(USE_LUT)
    ) u_update (
        .crc_in  (crc_base),
        .data_in (data_in),
        .crc_out (crc_upd)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (pkt_start && !pkt_end) state_d = ST_ACCUM;   // open
            end
            ST_ACCUM: begin
                if (pkt_end && !pkt_start) state_d = ST_IDLE;    // close
                else if (pkt_end)          state_d = ST_IDLE;    // open+close
                else                       state_d = ST_ACCUM;   // accumulate / restart
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath and verdict
    always_comb begin
        crc_d = accept ? crc_upd : crc_base;
        cnt_d = cnt_base;
        if (accept && cnt_base < CNT_MIN) cnt_d = cnt_base + 1'b1;
        ok_d   = closing && (crc_d == RESIDUE) && (cnt_d >= CNT_MIN);
        fail_d = closing && !ok_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q  <= INIT;
            cnt_q  <= '0;
            ok_q   <= 1'b0;
            fail_q <= 1'b0;
        end else begin
            crc_q  <= crc_d;
            cnt_q  <= cnt_d;
            ok_q   <= ok_d;
            fail_q <= fail_d;
        end
    end

    assign crc_value = crc_q;
    assign crc_ok    = ok_q;
    assign crc_fail  = fail_q;

    assert_start_preset_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_start && !data_valid) |=> (crc_value == INIT));

    assert_idle_ignores_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !pkt_start) |=> ($stable(crc_value) && !crc_ok && !crc_fail));

    assert_verdict_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({crc_ok, crc_fail}));

    assert_verdict_after_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (crc_ok || crc_fail) |-> $past(pkt_end));

    assert_ok_means_residue_R5: assert property (@(posedge clk) disable iff (!rst_n)
        crc_ok |-> (crc_value == RESIDUE));

    assert_hold_without_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!data_valid && !pkt_start) |=> $stable(crc_value));
endmodule

// File: tb/crc16_residual_check_tb.sv
module crc16_residual_check_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pkt_start = 1'b0, pkt_end = 1'b0, data_valid = 1'b0;
    logic [7:0] data_in = 8'h00;
    logic [15:0] crc_value, crc_value_t;
    logic        crc_ok, crc_fail, crc_ok_t, crc_fail_t;

    int n_tests = 0;
    int n_fail  = 0;
    bit compare_en = 1'b0;

    // reference model state
    logic [15:0] m_crc = 16'hFFFF;
    bit          m_act = 1'b0;
    int          m_cnt = 0;
    bit          m_ok = 1'b0, m_fail = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    crc16_residual_check #(.USE_LUT(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .pkt_start(pkt_start), .pkt_end(pkt_end),
        .data_valid(data_valid), .data_in(data_in),
        .crc_value(crc_value), .crc_ok(crc_ok), .crc_fail(crc_fail));

    crc16_residual_check #(.USE_LUT(1'b1)) dut_t (
        .clk(clk), .rst_n(rst_n), .pkt_start(pkt_start), .pkt_end(pkt_end),
        .data_valid(data_valid), .data_in(data_in),
        .crc_value(crc_value_t), .crc_ok(crc_ok_t), .crc_fail(crc_fail_t));

    function automatic logic [15:0] ref_byte(input logic [15:0] c_in, input logic [7:0] d);
        logic [15:0] c;
        c = c_in ^ {8'h00, d};
        for (int s = 0; s < 8; s++) c = c[0] ? ((c >> 1) ^ 16'hA001) : (c >> 1);
        return c;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural model, updated from tb-driven inputs
    always @(posedge clk) begin
        logic [15:0] c;
        int cnt;
        bit acc, cls, ok;
        if (!rst_n) begin
            m_crc = 16'hFFFF; m_act = 0; m_cnt = 0; m_ok = 0; m_fail = 0;
        end else begin
            c   = pkt_start ? 16'hFFFF : m_crc;
            cnt = pkt_start ? 0 : m_cnt;
            acc = data_valid && (pkt_start || m_act);
            if (acc) begin c = ref_byte(c, data_in); cnt++; end
            cls = pkt_end && (pkt_start || m_act);
            ok  = cls && (c == 16'hB001) && (cnt >= 2);
            m_ok = ok; m_fail = cls && !ok;
            m_act = cls ? 1'b0 : (pkt_start ? 1'b1 : m_act);
            m_crc = c; m_cnt = cnt;
        end
    end

    // per-cycle comparison
    always @(negedge clk) begin
        if (compare_en) begin
            check("R3 crc_value", 32'(crc_value), 32'(m_crc));
            check("R5 crc_ok", 32'(crc_ok), 32'(m_ok));
            check("R5 crc_fail", 32'(crc_fail), 32'(m_fail));
            check("R8 lut crc_value", 32'(crc_value_t), 32'(crc_value));
            check("R8 lut verdict", 32'({crc_ok_t, crc_fail_t}), 32'({crc_ok, crc_fail}));
        end
    end

    task automatic drive(input bit s, input bit v, input bit e, input logic [7:0] d);
        @(negedge clk);
        pkt_start = s; data_valid = v; pkt_end = e; data_in = d;
    endtask

    task automatic idle();
        drive(0, 0, 0, 8'h00);
    endtask

    // sends bytes + appended CRC; corrupt flips one bit; start carries the first byte
    task automatic send_packet(input int len, input bit corrupt, input bit gaps);
        logic [15:0] c;
        logic [7:0]  b [$];
        c = 16'hFFFF;
        for (int i = 0; i < len; i++) begin
            b.push_back(8'($urandom));
            c = ref_byte(c, b[i]);
        end
        b.push_back(~c[7:0]);
        b.push_back(~c[15:8]);
        if (corrupt) b[0] = b[0] ^ 8'h10;
        for (int i = 0; i < b.size(); i++) begin
            if (gaps && i > 0 && (i % 3 == 0)) drive(0, 0, 0, 8'hA5);
            drive(i == 0, 1, i == b.size() - 1, b[i]);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset crc_value", 32'(crc_value), 32'hFFFF);
        check("R1 reset verdict", 32'({crc_ok, crc_fail}), 32'h0);
        rst_n = 1'b1;
        compare_en = 1'b1;

        // R4: bytes and end while idle
        drive(0, 1, 0, 8'h3C);
        drive(0, 1, 1, 8'h77);
        idle();
        check("R4 idle crc_value", 32'(crc_value), 32'hFFFF);
        check("R4 idle verdict", 32'({crc_ok, crc_fail}), 32'h0);

        // R2/R3: preset then byte 0xFE -> T[0x01]^0x00FF
        drive(1, 0, 0, 8'h00);
        drive(0, 1, 0, 8'hFE);
        idle();
        check("R3 byte FE", 32'(crc_value), 32'hC03E);
        // R2: start with first byte in same cycle
        drive(1, 1, 0, 8'hFE);
        idle();
        check("R2 start with byte", 32'(crc_value), 32'hC03E);
        // R3: byte 0xAB after preset -> T[0x54]^0x00FF = 0xFFFE
        drive(1, 1, 0, 8'hAB);
        idle();
        check("R3 byte AB", 32'(crc_value), 32'hFFFE);
        drive(0, 0, 1, 8'h00);
        idle();
        check("R6 one byte fails", 32'({crc_ok, crc_fail}), 32'h1);

        // R6: empty packet
        drive(1, 0, 1, 8'h00);
        idle();
        check("R6 empty fails", 32'({crc_ok, crc_fail}), 32'h1);

        // R5: good packet, last byte with end
        send_packet(4, 0, 0);
        idle();
        check("R5 good packet ok", 32'({crc_ok, crc_fail}), 32'h2);
        check("R5 residue", 32'(crc_value), 32'hB001);
        idle();
        check("R5 pulse one cycle", 32'({crc_ok, crc_fail}), 32'h0);

        // R5: corrupted packet
        send_packet(6, 1, 1);
        idle();
        check("R5 corrupt fails", 32'({crc_ok, crc_fail}), 32'h1);

        // R6: two CRC bytes only (zero data) is a valid 2-byte packet
        send_packet(0, 0, 0);
        idle();
        check("R6 two bytes ok", 32'({crc_ok, crc_fail}), 32'h2);

        // R7: back-to-back packets
        send_packet(3, 0, 0);
        send_packet(5, 0, 1);
        idle();
        check("R7 back-to-back ok", 32'({crc_ok, crc_fail}), 32'h2);

        // R9: restart mid-packet
        drive(1, 1, 0, 8'h12);
        drive(0, 1, 0, 8'h34);
        send_packet(2, 0, 0);
        idle();
        check("R9 restart ok", 32'({crc_ok, crc_fail}), 32'h2);

        // random traffic
        for (int p = 0; p < 60; p++) begin
            send_packet(1 + (p % 9), (p % 4) == 3, (p % 2) == 1);
            if (p % 5 == 0) idle();
        end
        idle();
        idle();

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule